// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the software-visible register slave of a color LCD controller. It sits on a simple 32-bit peripheral bus with word addressing over a 4 KB window. It holds the four panel timing words, the base addresses for the upper and lower panel halves, the control word and an interrupt mask. It also holds a raw interrupt status that is set by one-cycle pulses from the rest of the controller. It presents the decoded control fields, the two base addresses and the active panel geometry to the display pipeline. The geometry is derived from packed fields of the first two timing words.

A two-bit layout strap selects one of three register layouts. Layout 0 places the interrupt mask below the control word. Layouts 1 and 2 swap those two addresses for both reads and writes. Layout 2 also reports a different identification byte sequence. The top eight words of the window are read-only identification bytes. The interrupt output is the OR of the status bits that are enabled in the mask.

Top module: `lcd_regif`

## Requirements
- R1: After reset every register, the interrupt status, the active columns and rows, `panel_enabled` and `irq` are zero.
- R2: A write to word 0 stores the full 32-bit timing word. From the next cycle, `active_cols` equals ((value & 0xFC) + 4) * 4 and the rows are unchanged.
- R3: A write to word 1 stores the full word. From the next cycle, `active_rows` equals (value & 0x3FF) + 1 and the columns are unchanged.
- R4: The control word reads back all 32 bits. `panel_enabled` is high only when bit 0 (enable) and bit 11 (power) are both set. `pix_depth` shows bits 3:1, `bgr_order` shows bit 8, `be_bytes` shows bit 9 and `be_pixels` shows bit 10.
- R5: With `layout_sel` = 0, word 6 is the interrupt mask and word 7 is the control word. With any other value these two addresses are swapped for reads and writes. The mask keeps bits NUM_SRC-1:0 (4:0 by default) and reads back zero-extended.
- R6: A one-cycle pulse on `irq_src[k]` sets status bit k at the next edge. Word 8 reads the raw status and word 9 reads status AND mask. `irq` is high exactly when status AND mask is nonzero.
- R7: Writing word 10 clears each status bit whose data bit is one. A source pulse in the same cycle as a clear wins, and that bit stays set.
- R8: Words 2 to 5 store the full written word. Words 4 and 5 hold the upper and lower base addresses, which drive `upper_base` and `lower_base`. Words 11 and 12 read back the upper and lower base.
- R9: The top eight words of the window (byte offsets 0xFE0 to 0xFFC) return one identification byte each, selected by the low three word-address bits. Layouts 0 and 1 return 10,11,04,00,0D,F0,05,B1 (hex). Layout 2 returns 11,11,24,00,0D,F0,05,B1.
- R10: Reads of words 10 and 13 up to the identification window return zero. Writes to words 8, 9, 11, 12, the unmapped words and the identification words change no register, status bit or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| layout_sel | input | 2 | Register layout strap |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | ADDR_W | Word address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_src | input | NUM_SRC | One-cycle interrupt source pulses |
| irq | output | 1 | OR of masked status bits |
| panel_enabled | output | 1 | Enable and power both set |
| pix_depth | output | 3 | Pixel-depth code |
| bgr_order | output | 1 | BGR colour order |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order within a byte |
| active_cols | output | 11 | Derived active columns |
| active_rows | output | 11 | Derived active rows |
| upper_base | output | 32 | Upper panel base address |
| lower_base | output | 32 | Lower panel base address |

## Verification
The hardest case to reach is a status clear that lands in the same cycle as a source pulse on a bit that the clear also names. Only that collision shows whether setting has priority. The bench drives the clear write and the pulse on the same falling edge, then reads raw status and `irq` before any further stimulus. The swapped layouts need a strap change under reset, so the bench resets once per layout. For each layout it sweeps every word address against its own model.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;

    localparam int DATA_W      = 32;
    localparam int NUM_TIMING  = 4;
    localparam int GEOM_W      = 11;
    localparam int ID_WORDS    = 8;

    typedef enum logic [3:0] {
        RID_TIM0, RID_TIM1, RID_TIM2, RID_TIM3,
        RID_UPBASE, RID_LPBASE, RID_MASK, RID_CTRL,
        RID_RAW, RID_MASKED, RID_CLEAR, RID_UPCUR,
        RID_LPCUR, RID_IDENT, RID_NONE
    } reg_id_e;

    typedef struct packed {
        logic       enable;
        logic       power;
        logic [2:0] depth;
        logic       bgr;
        logic       be_byte;
        logic       be_pixel;
    } ctrl_fields_t;

    function automatic ctrl_fields_t unpack_ctrl(input logic [DATA_W-1:0] v);
        ctrl_fields_t f;
        f.enable   = v[0];
        f.power    = v[11];
        f.depth    = v[3:1];
        f.bgr      = v[8];
        f.be_byte  = v[9];
        f.be_pixel = v[10];
        return f;
    endfunction

    // ((v & 0xFC) + 4) * 4 == (v[7:2] + 1) * 16
    function automatic logic [GEOM_W-1:0] cols_from_timing(input logic [DATA_W-1:0] v);
        logic [6:0] units;
        units = {1'b0, v[7:2]} + 7'd1;
        return {units, 4'b0000};
    endfunction

    function automatic logic [GEOM_W-1:0] rows_from_timing(input logic [DATA_W-1:0] v);
        return {1'b0, v[9:0]} + GEOM_W'(1);
    endfunction

    function automatic logic layout_swapped(input logic [1:0] sel);
        return sel != 2'd0;
    endfunction

    function automatic logic [7:0] ident_byte(input logic alt_set, input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = alt_set ? 8'h11 : 8'h10;
            3'd1:    b = 8'h11;
            3'd2:    b = alt_set ? 8'h24 : 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_regif_decode.sv
module lcd_regif_decode
    import lcd_regif_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [1:0]        layout_sel,
    output reg_id_e           rid,
    output logic [2:0]        id_idx
);
    localparam int WORDS    = 1 << ADDR_W;
    localparam int ID_FIRST = WORDS - ID_WORDS;

    logic swapped;
    assign swapped = layout_swapped(layout_sel);
    assign id_idx  = word_addr[2:0];

    always_comb begin
        rid = RID_NONE;
        if (word_addr >= ADDR_W'(ID_FIRST)) begin
            rid = RID_IDENT;
        end else begin
            case (word_addr)
                ADDR_W'(0):  rid = RID_TIM0;
                ADDR_W'(1):  rid = RID_TIM1;
                ADDR_W'(2):  rid = RID_TIM2;
                ADDR_W'(3):  rid = RID_TIM3;
                ADDR_W'(4):  rid = RID_UPBASE;
                ADDR_W'(5):  rid = RID_LPBASE;
                ADDR_W'(6):  rid = swapped ? RID_CTRL : RID_MASK;
                ADDR_W'(7):  rid = swapped ? RID_MASK : RID_CTRL;
                ADDR_W'(8):  rid = RID_RAW;
                ADDR_W'(9):  rid = RID_MASKED;
                ADDR_W'(10): rid = RID_CLEAR;
                ADDR_W'(11): rid = RID_UPCUR;
                ADDR_W'(12): rid = RID_LPCUR;
                default:     rid = RID_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lcd_regif_irq.sv
module lcd_regif_irq #(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_wdata,
    output logic [NUM_SRC-1:0] raw_status,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] masked,
    output logic               irq
);
    logic [NUM_SRC-1:0] clr_bits;
    assign clr_bits = clr_we ? clr_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_status <= '0;
            mask       <= '0;
        end else begin
            // a pulse in the same cycle overrides the clear
            raw_status <= (raw_status & ~clr_bits) | src;
            if (mask_we) mask <= mask_wdata;
        end
    end

    assign masked = raw_status & mask;
    assign irq    = |masked;
endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
    import lcd_regif_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int NUM_SRC = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           layout_sel,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_SRC-1:0]   irq_src,
    output logic                 irq,
    output logic                 panel_enabled,
    output logic [2:0]           pix_depth,
    output logic                 bgr_order,
    output logic                 be_bytes,
    output logic                 be_pixels,
    output logic [GEOM_W-1:0]    active_cols,
    output logic [GEOM_W-1:0]    active_rows,
    output logic [31:0]          upper_base,
    output logic [31:0]          lower_base
);
    reg_id_e    rid;
    logic [2:0] id_idx;
    logic       wr;

    logic [NUM_TIMING-1:0][DATA_W-1:0] timing_q;
    logic [DATA_W-1:0]  ctrl_q, upbase_q, lpbase_q;
    logic [GEOM_W-1:0]  cols_q, rows_q;
    logic [NUM_SRC-1:0] raw_status, mask_q, masked;
    ctrl_fields_t       cf;

    assign wr = bus_sel && bus_we;

    lcd_regif_decode #(.ADDR_W(ADDR_W)) u_decode (
        .word_addr  (bus_addr),
        .layout_sel (layout_sel),
        .rid        (rid),
        .id_idx     (id_idx)
    );

    lcd_regif_irq #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .src        (irq_src),
        .mask_we    (wr && rid == RID_MASK),
        .mask_wdata (bus_wdata[NUM_SRC-1:0]),
        .clr_we     (wr && rid == RID_CLEAR),
        .clr_wdata  (bus_wdata[NUM_SRC-1:0]),
        .raw_status (raw_status),
        .mask       (mask_q),
        .masked     (masked),
        .irq        (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            timing_q <= '0;
            ctrl_q   <= '0;
            upbase_q <= '0;
            lpbase_q <= '0;
            cols_q   <= '0;
            rows_q   <= '0;
        end else if (wr) begin
            for (int i = 0; i < NUM_TIMING; i++) begin
                if (rid == reg_id_e'(4'(i))) timing_q[i] <= bus_wdata;
            end
            if (rid == RID_TIM0)   cols_q   <= cols_from_timing(bus_wdata);
            if (rid == RID_TIM1)   rows_q   <= rows_from_timing(bus_wdata);
            if (rid == RID_CTRL)   ctrl_q   <= bus_wdata;
            if (rid == RID_UPBASE) upbase_q <= bus_wdata;
            if (rid == RID_LPBASE) lpbase_q <= bus_wdata;
        end
    end

    always_comb begin
        case (rid)
            RID_TIM0, RID_TIM1,
            RID_TIM2, RID_TIM3:  bus_rdata = timing_q[rid[1:0]];
            RID_UPBASE,
            RID_UPCUR:           bus_rdata = upbase_q;
            RID_LPBASE,
            RID_LPCUR:           bus_rdata = lpbase_q;
            RID_MASK:            bus_rdata = DATA_W'(mask_q);
            RID_CTRL:            bus_rdata = ctrl_q;
            RID_RAW:             bus_rdata = DATA_W'(raw_status);
            RID_MASKED:          bus_rdata = DATA_W'(masked);
            RID_IDENT:           bus_rdata = DATA_W'(ident_byte(layout_sel[1], id_idx));
            default:             bus_rdata = '0;
        endcase
    end

    assign cf            = unpack_ctrl(ctrl_q);
    assign panel_enabled = cf.enable && cf.power;
    assign pix_depth     = cf.depth;
    assign bgr_order     = cf.bgr;
    assign be_bytes      = cf.be_byte;
    assign be_pixels     = cf.be_pixel;
    assign active_cols   = cols_q;
    assign active_rows   = rows_q;
    assign upper_base    = upbase_q;
    assign lower_base    = lpbase_q;
endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk #(
    parameter int ADDR_W  = 10,
    parameter int NUM_SRC = 5
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         layout_sel,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NUM_SRC-1:0] irq_src,
    input logic               irq,
    input logic               panel_enabled,
    input logic [10:0]        active_cols,
    input logic [10:0]        active_rows,
    input logic [NUM_SRC-1:0] raw_status
);
    localparam int ID_FIRST = (1 << ADDR_W) - 8;

    logic              wr;
    logic [ADDR_W-1:0] ctrl_word, mask_word;
    assign wr        = bus_sel && bus_we;
    assign ctrl_word = (layout_sel == 2'd0) ? ADDR_W'(7) : ADDR_W'(6);
    assign mask_word = (layout_sel == 2'd0) ? ADDR_W'(6) : ADDR_W'(7);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !panel_enabled && active_cols == 11'd0 &&
                        active_rows == 11'd0 && raw_status == '0));

    assert_cols_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == ADDR_W'(0)) |=>
            active_cols == ((11'($past(bus_wdata[7:0]) & 8'hFC) + 11'd4) * 11'd4));

    assert_rows_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == ADDR_W'(1)) |=>
            active_rows == (11'($past(bus_wdata[9:0])) + 11'd1));

    assert_enable_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == ctrl_word) |=>
            panel_enabled == ($past(bus_wdata[0]) && $past(bus_wdata[11])));

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(|irq_src) || $past(wr && bus_addr == mask_word)));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (|irq_src) |=> ((raw_status & $past(irq_src)) == $past(irq_src)));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > ADDR_W'(12) && bus_addr < ADDR_W'(ID_FIRST)) |-> bus_rdata == 32'd0);
endmodule

bind lcd_regif lcd_regif_chk #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/lcd_regif_bench.sv
`timescale 1ns/1ps
module lcd_regif_bench;
    localparam int AW = 10;
    localparam int NS = 5;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0, rst = 1'b1;
    logic [1:0]    layout_sel = 2'd0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0, bus_rdata;
    logic [NS-1:0] irq_src = '0;
    logic          irq, panel_enabled, bgr_order, be_bytes, be_pixels;
    logic [2:0]    pix_depth;
    logic [10:0]   active_cols, active_rows;
    logic [31:0]   upper_base, lower_base;

    lcd_regif #(.ADDR_W(AW), .NUM_SRC(NS)) u_lcd_regif (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0;

    logic [31:0] m_tim [4];
    logic [31:0] m_up, m_lp, m_ctrl;
    logic [NS-1:0] m_mask, m_raw;
    int m_cols, m_rows;
    logic [7:0] id_a [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [7:0] id_b [8] = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_tim[i] = '0;
        m_up = '0; m_lp = '0; m_ctrl = '0; m_mask = '0; m_raw = '0;
        m_cols = 0; m_rows = 0;
    endtask

    function automatic logic [31:0] exp_read(input int w);
        if (w >= WORDS - 8) return {24'd0, (layout_sel == 2'd2) ? id_b[w - (WORDS - 8)] : id_a[w - (WORDS - 8)]};
        case (w)
            0, 1, 2, 3: return m_tim[w];
            4, 11:      return m_up;
            5, 12:      return m_lp;
            6:          return (layout_sel == 2'd0) ? 32'(m_mask) : m_ctrl;
            7:          return (layout_sel == 2'd0) ? m_ctrl : 32'(m_mask);
            8:          return 32'(m_raw);
            9:          return 32'(m_raw & m_mask);
            default:    return 32'd0;
        endcase
    endfunction

    task automatic model_write(input int w, input logic [31:0] d);
        case (w)
            0: begin m_tim[0] = d; m_cols = ((d & 32'hFC) + 4) * 4; end
            1: begin m_tim[1] = d; m_rows = (d & 32'h3FF) + 1; end
            2, 3: m_tim[w] = d;
            4: m_up = d;
            5: m_lp = d;
            6: if (layout_sel == 2'd0) m_mask = d[NS-1:0]; else m_ctrl = d;
            7: if (layout_sel == 2'd0) m_ctrl = d; else m_mask = d[NS-1:0];
            10: m_raw = m_raw & ~d[NS-1:0];
            default: ;
        endcase
    endtask

    task automatic do_reset(input logic [1:0] lay);
        @(negedge clk);
        rst = 1'b1; layout_sel = lay;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic bus_write(input int w, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(w); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        model_write(w, d);
    endtask

    // pulse sources, optionally with a status clear write in the same cycle
    task automatic pulse(input logic [NS-1:0] s, input logic clr, input logic [31:0] cd);
        @(negedge clk);
        irq_src = s;
        if (clr) begin bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(10); bus_wdata = cd; end
        @(negedge clk);
        irq_src = '0; bus_sel = 1'b0; bus_we = 1'b0;
        m_raw = (m_raw & ~(clr ? cd[NS-1:0] : '0)) | s;
    endtask

    task automatic bus_read(input int w, output logic [31:0] d);
        bus_addr = AW'(w); bus_sel = 1'b1; bus_we = 1'b0;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic check_outs(input string req);
        @(negedge clk); #0.5;
        chk(req, "irq", 32'(irq), 32'(|(m_raw & m_mask)));
        chk(req, "enabled", 32'(panel_enabled), 32'(m_ctrl[0] & m_ctrl[11]));
        chk(req, "depth", 32'(pix_depth), 32'(m_ctrl[3:1]));
        chk(req, "bgr/bebyte/bepix", {29'd0, bgr_order, be_bytes, be_pixels}, {29'd0, m_ctrl[8], m_ctrl[9], m_ctrl[10]});
        chk(req, "cols", 32'(active_cols), 32'(m_cols));
        chk(req, "rows", 32'(active_rows), 32'(m_rows));
        chk(req, "upper_base", upper_base, m_up);
        chk(req, "lower_base", lower_base, m_lp);
    endtask

    task automatic sweep_reads(input string req);
        logic [31:0] d;
        @(negedge clk);
        for (int w = 0; w < WORDS; w++) begin
            bus_read(w, d);
            chk(req, $sformatf("read word %0d", w), d, exp_read(w));
        end
    endtask

    initial begin : watchdog
        #800000;
        checks++; errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        // R1 reset state
        do_reset(2'd0);
        check_outs("R1");
        sweep_reads("R1");

        // R2 exhaustive over the column field
        for (int v = 0; v < 256; v++) begin
            bus_write(0, 32'h00A5_0000 | 32'(v));
            @(negedge clk); #0.5;
            chk("R2", "cols", 32'(active_cols), 32'(((v & 32'hFC) + 4) * 4));
            bus_read(0, d);
            chk("R2", "timing0 readback", d, 32'h00A5_0000 | 32'(v));
        end
        chk("R2", "rows untouched", 32'(active_rows), 32'd0);

        // R3 exhaustive over the row field
        for (int v = 0; v < 1024; v++) begin
            bus_write(1, 32'hF000_FC00 | 32'(v));
            @(negedge clk); #0.5;
            chk("R3", "rows", 32'(active_rows), 32'(v + 1));
        end
        check_outs("R3");

        // R8 other timing words and bases
        bus_write(2, 32'hDEAD_BEEF);
        bus_write(3, 32'h0BAD_F00D);
        bus_write(4, 32'h8000_1000);
        bus_write(5, 32'h8004_0000);
        check_outs("R8");
        for (int w = 0; w < 13; w++) begin
            bus_read(w, d);
            chk("R8", $sformatf("word %0d", w), d, exp_read(w));
        end

        // R4 all combinations of enable, power, colour order and endian bits
        for (int i = 0; i < 32; i++) begin
            d = {20'h0A5A5, i[4] ? 1'b1 : 1'b0, 1'b0, i[3], i[2], 4'b0000, 3'(i), i[0]};
            d[11] = i[1];
            d[10] = i[4];
            d[9]  = i[3];
            d[8]  = i[2];
            bus_write(7, d);
            check_outs("R4");
            bus_read(7, d);
            chk("R4", "ctrl readback", d, m_ctrl);
        end

        // R6 masked status and irq
        bus_write(6, 32'hFFFF_FFF5);
        pulse(5'b00010, 1'b0, 32'd0);
        check_outs("R6");
        chk("R6", "irq low on unmasked source", 32'(irq), 32'd0);
        pulse(5'b00100, 1'b0, 32'd0);
        check_outs("R6");
        chk("R6", "irq high", 32'(irq), 32'd1);
        for (int w = 6; w < 10; w++) begin
            bus_read(w, d);
            chk("R6", $sformatf("word %0d", w), d, exp_read(w));
        end

        // R7 clear, then a clear colliding with a set
        pulse(5'b00000, 1'b1, 32'h0000_0004);
        check_outs("R7");
        pulse(5'b00001, 1'b1, 32'h0000_001F);
        check_outs("R7");
        bus_read(8, d);
        chk("R7", "set wins over clear", d, 32'h1);
        pulse(5'b00000, 1'b1, 32'hFFFF_FFFF);
        bus_read(8, d);
        chk("R7", "cleared", d, 32'h0);

        // R10 writes to read-only and unmapped words are ignored
        pulse(5'b10000, 1'b0, 32'd0);
        bus_write(8, 32'hFFFF_FFFF);
        bus_write(9, 32'hFFFF_FFFF);
        bus_write(11, 32'hFFFF_FFFF);
        bus_write(12, 32'hFFFF_FFFF);
        for (int w = 13; w < WORDS; w++) bus_write(w, 32'hFFFF_FFFF);
        check_outs("R10");
        sweep_reads("R10");

        // R5 and R9 for the swapped layouts
        for (int lay = 1; lay < 3; lay++) begin
            do_reset(2'(lay));
            check_outs("R1");
            bus_write(6, 32'h0000_0F03);
            bus_write(7, 32'h0000_001B);
            pulse(5'b11000, 1'b0, 32'd0);
            check_outs("R5");
            chk("R5", "enabled via word 6", 32'(panel_enabled), 32'd1);
            sweep_reads("R9");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule